// File: doc/BRIEF.md
# Two-level interrupt request router

This block gathers level-sensitive interrupt lines from peripherals and steers each line to one of two processor request outputs: a normal request and a fast request. Software chooses the route for each line by setting bits in one of two enable masks. The two masks interlock, so a line can belong to at most one level. For each level, software can see three views through a small 32-bit register bus: the raw line state, the masked state, and the mask itself. A separate write-only register lets software raise a programmed interrupt at either level. That interrupt ignores the masks.

Bit 0 of every signal and status view is reserved for the fast level's combined request. The normal level can therefore see that a fast request is pending. Bit 1 carries the programmed interrupt of that level. Bits 31 down to 2 carry the peripheral lines. Reads are combinational from the address. Writes take effect at the clock edge. The two request outputs are registered by default.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: After reset, both enable masks and both programmed-interrupt bits are 0, every status view reads 0, and both request outputs are low.
- R2: Each signal view is built as follows. Bits 31:2 are the raw `src_i` lines. Bit 1 is the level's programmed interrupt. Bit 0 is the fast level's combined request. The normal signal view is at 0x004 and the fast signal view is at 0x104.
- R3: Each status view has the same bits 1:0 as its signal view. Bits 31:2 are `src_i` ANDed with that level's enable mask. The normal status view is at 0x000 and the fast status view is at 0x100.
- R4: `irq_o` is the OR of normal status bits 31:1, and `fiq_o` is the OR of fast status bits 31:1. Each output appears one clock after the state that produces it.
- R5: A write to an enable mask (normal at 0x008, fast at 0x108) sets every bit written as 1 and leaves every other bit unchanged. Writing 0 never disables a line.
- R6: A write to a clear register (normal at 0x00C, fast at 0x10C) removes every bit written as 1 from that level's mask.
- R7: Setting a mask bit at one level clears the same bit at the other level, so no line is ever enabled at both levels.
- R8: A write to the programmed-interrupt register at 0x010 loads bit 2 into the fast programmed interrupt and bit 1 into the normal programmed interrupt. This sets or clears each one, regardless of the enable masks.
- R9: The clear registers, the programmed-interrupt register and unmapped addresses all read 0. Enable mask bits 1:0 always read 0.
- R10: `src_i` bits 1:0 have no effect on any view or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Register byte address |
| wr_en | input | 1 | Write strobe for the current address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data |
| src_i | input | 32 | Peripheral interrupt lines, bits 31:2 used |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions assume that the bus carries at most one write per cycle and that addresses are word aligned, so the two masks are never written in the same cycle. The stimulus keeps to this: every write lasts exactly one clock period, inputs change only on falling edges, and there are no back-to-back writes to the two levels. The properties on mask persistence also rely on clear and cross-level writes being the only ways a mask bit can fall. Every register access in the bench goes through the bus and observes only those effects.

// File: rtl/irq_fiq_pkg.sv
package irq_fiq_pkg;

   localparam int unsigned NUM_LVL  = 2;
   localparam int unsigned LVL_IRQ  = 0;
   localparam int unsigned LVL_FIQ  = 1;

   localparam int unsigned BASE_IRQ = 32'h000;
   localparam int unsigned BASE_FIQ = 32'h100;
   localparam int unsigned OFS_STA  = 32'h0;
   localparam int unsigned OFS_SIG  = 32'h4;
   localparam int unsigned OFS_EN   = 32'h8;
   localparam int unsigned OFS_CLR  = 32'hC;
   localparam int unsigned ADR_SWI  = 32'h010;

   localparam int unsigned SWI_BIT_IRQ = 1;
   localparam int unsigned SWI_BIT_FIQ = 2;

   typedef enum logic [2:0] {
      VIEW_NONE,
      VIEW_STA,
      VIEW_SIG,
      VIEW_EN
   } view_e;

   typedef struct packed {
      view_e kind;
      logic  lvl;
   } rd_sel_t;

   function automatic int unsigned lvl_base(input int unsigned lvl);
      return (lvl == LVL_FIQ) ? BASE_FIQ : BASE_IRQ;
   endfunction

endpackage

// File: rtl/ifc_regdec.sv
module ifc_regdec
   import irq_fiq_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic               wr_en,
   output logic [NUM_LVL-1:0] en_wr,
   output logic [NUM_LVL-1:0] clr_wr,
   output logic               swi_wr,
   output rd_sel_t            rd_sel
);

   logic [NUM_LVL-1:0] hit_sta, hit_sig, hit_en, hit_clr;

   for (genvar lv = 0; lv < NUM_LVL; lv++) begin : g_lvl
      localparam int unsigned B = lvl_base(lv);
      assign hit_sta[lv] = (addr == ADDR_W'(B + OFS_STA));
      assign hit_sig[lv] = (addr == ADDR_W'(B + OFS_SIG));
      assign hit_en[lv]  = (addr == ADDR_W'(B + OFS_EN));
      assign hit_clr[lv] = (addr == ADDR_W'(B + OFS_CLR));
      assign en_wr[lv]   = wr_en & hit_en[lv];
      assign clr_wr[lv]  = wr_en & hit_clr[lv];
   end

   assign swi_wr = wr_en & (addr == ADDR_W'(ADR_SWI));

   always_comb begin
      rd_sel.kind = VIEW_NONE;
      rd_sel.lvl  = 1'b0;
      for (int lv = 0; lv < NUM_LVL; lv++) begin
         if (hit_sta[lv]) begin
            rd_sel.kind = VIEW_STA;
            rd_sel.lvl  = 1'(lv);
         end else if (hit_sig[lv]) begin
            rd_sel.kind = VIEW_SIG;
            rd_sel.lvl  = 1'(lv);
         end else if (hit_en[lv]) begin
            rd_sel.kind = VIEW_EN;
            rd_sel.lvl  = 1'(lv);
         end
      end
   end

endmodule

// File: rtl/ifc_mask_pair.sv
module ifc_mask_pair
   import irq_fiq_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_LVL-1:0]              en_wr,
   input  logic [NUM_LVL-1:0]              clr_wr,
   input  logic [DATA_W-1:0]               wdata,
   output logic [NUM_LVL-1:0][DATA_W-1:0]  en_q
);

   localparam logic [DATA_W-1:0] HW_MASK = {{(DATA_W-2){1'b1}}, 2'b00};

   logic [DATA_W-1:0] wbits;
   assign wbits = wdata & HW_MASK;

   for (genvar lv = 0; lv < NUM_LVL; lv++) begin : g_mask
      localparam int unsigned OTHER = NUM_LVL - 1 - lv;
      logic [DATA_W-1:0] nxt;

      always_comb begin
         nxt = en_q[lv];
         if (en_wr[lv])     nxt = nxt | wbits;
         if (en_wr[OTHER])  nxt = nxt & ~wbits;
         if (clr_wr[lv])    nxt = nxt & ~wdata;
         nxt = nxt & HW_MASK;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) en_q[lv] <= '0;
         else        en_q[lv] <= nxt;
      end
   end

endmodule

// File: rtl/ifc_level_view.sv
module ifc_level_view #(
   parameter int unsigned DATA_W  = 32,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] src,
   input  logic [DATA_W-1:0] en,
   input  logic              prog,
   input  logic              fiq_any,
   output logic [DATA_W-1:0] sig,
   output logic [DATA_W-1:0] sta,
   output logic              req_now,
   output logic              req_o
);

   logic [DATA_W-1:1] sta_hi;

   assign sta_hi  = {src[DATA_W-1:2] & en[DATA_W-1:2], prog};
   assign req_now = |sta_hi;
   assign sig     = {src[DATA_W-1:2], prog, fiq_any};
   assign sta     = {sta_hi, fiq_any};

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) req_o <= 1'b0;
         else        req_o <= req_now;
      end
   end else begin : g_comb
      assign req_o = req_now;
   end

endmodule

// File: rtl/irq_fiq_ctrl.sv
module irq_fiq_ctrl
   import irq_fiq_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 12,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [DATA_W-1:0] src_i,
   output logic              irq_o,
   output logic              fiq_o
);

   if (DATA_W < 4) begin : g_bad_width
      $error("irq_fiq_ctrl: DATA_W must be at least 4");
   end
   if (ADDR_W < 9) begin : g_bad_addr
      $error("irq_fiq_ctrl: ADDR_W must reach the fast level base");
   end

   logic [NUM_LVL-1:0]             en_wr, clr_wr;
   logic                           swi_wr;
   rd_sel_t                        rd_sel;
   logic [NUM_LVL-1:0][DATA_W-1:0] en_q;
   logic [NUM_LVL-1:0][DATA_W-1:0] sig_v, sta_v;
   logic [NUM_LVL-1:0]             req_now, req_o;
   logic [NUM_LVL-1:0]             prog;
   logic [DATA_W-1:0]              irq_en_q, fiq_en_q;
   logic                           swi_irq_q, swi_fiq_q;
   logic                           fiq_any;

   ifc_regdec #(.ADDR_W(ADDR_W)) u_dec (
      .addr   (addr),
      .wr_en  (wr_en),
      .en_wr  (en_wr),
      .clr_wr (clr_wr),
      .swi_wr (swi_wr),
      .rd_sel (rd_sel)
   );

   ifc_mask_pair #(.DATA_W(DATA_W)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_wr  (en_wr),
      .clr_wr (clr_wr),
      .wdata  (wr_data),
      .en_q   (en_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         swi_irq_q <= 1'b0;
         swi_fiq_q <= 1'b0;
      end else if (swi_wr) begin
         swi_irq_q <= wr_data[SWI_BIT_IRQ];
         swi_fiq_q <= wr_data[SWI_BIT_FIQ];
      end
   end

   assign irq_en_q       = en_q[LVL_IRQ];
   assign fiq_en_q       = en_q[LVL_FIQ];
   assign prog[LVL_IRQ]  = swi_irq_q;
   assign prog[LVL_FIQ]  = swi_fiq_q;
   assign fiq_any        = req_now[LVL_FIQ];

   for (genvar lv = 0; lv < NUM_LVL; lv++) begin : g_view
      ifc_level_view #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_view (
         .clk     (clk),
         .rst_n   (rst_n),
         .src     (src_i),
         .en      (en_q[lv]),
         .prog    (prog[lv]),
         .fiq_any (fiq_any),
         .sig     (sig_v[lv]),
         .sta     (sta_v[lv]),
         .req_now (req_now[lv]),
         .req_o   (req_o[lv])
      );
   end

   assign irq_o = req_o[LVL_IRQ];
   assign fiq_o = req_o[LVL_FIQ];

   always_comb begin
      unique case (rd_sel.kind)
         VIEW_STA: rd_data = sta_v[rd_sel.lvl];
         VIEW_SIG: rd_data = sig_v[rd_sel.lvl];
         VIEW_EN:  rd_data = en_q[rd_sel.lvl];
         default:  rd_data = '0;
      endcase
   end

endmodule

// File: rtl/irq_fiq_ctrl_chk.sv
module irq_fiq_ctrl_chk
   import irq_fiq_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 12,
   parameter bit          OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] irq_en_q,
   input logic [DATA_W-1:0] fiq_en_q,
   input logic              swi_irq_q,
   input logic              swi_fiq_q,
   input logic              irq_o,
   input logic              fiq_o
);

   localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(BASE_IRQ + OFS_EN);
   localparam logic [ADDR_W-1:0] A_FEN  = ADDR_W'(BASE_FIQ + OFS_EN);
   localparam logic [ADDR_W-1:0] A_ICLR = ADDR_W'(BASE_IRQ + OFS_CLR);
   localparam logic [ADDR_W-1:0] A_FCLR = ADDR_W'(BASE_FIQ + OFS_CLR);
   localparam logic [ADDR_W-1:0] A_SWI  = ADDR_W'(ADR_SWI);

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |-> (irq_en_q == '0 && fiq_en_q == '0 && !irq_o && !fiq_o));

   assert_never_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en_q & fiq_en_q) == '0);

   assert_cross_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_FEN) |=> ((irq_en_q & $past(wr_data)) == '0));

   assert_clear_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_ICLR) |=> ((irq_en_q & $past(wr_data)) == '0));

   assert_clear_fiq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_FCLR) |=> ((fiq_en_q & $past(wr_data)) == '0));

   assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (addr == A_ICLR || addr == A_FEN))
      |=> ((irq_en_q & $past(irq_en_q)) == $past(irq_en_q)));

   assert_fiq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (addr == A_FCLR || addr == A_IEN))
      |=> ((fiq_en_q & $past(fiq_en_q)) == $past(fiq_en_q)));

   assert_swi_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_SWI)
      |=> (swi_fiq_q == $past(wr_data[SWI_BIT_FIQ]) && swi_irq_q == $past(wr_data[SWI_BIT_IRQ])));

   if (OUT_REG) begin : g_reg_out
      assert_swi_fiq_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
         swi_fiq_q |=> fiq_o);
      assert_swi_irq_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
         swi_irq_q |=> irq_o);
   end else begin : g_comb_out
      assert_swi_fiq_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
         swi_fiq_q |-> fiq_o);
      assert_swi_irq_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
         swi_irq_q |-> irq_o);
   end

endmodule

bind irq_fiq_ctrl irq_fiq_ctrl_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .OUT_REG(OUT_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .addr      (addr),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .irq_en_q  (irq_en_q),
   .fiq_en_q  (fiq_en_q),
   .swi_irq_q (swi_irq_q),
   .swi_fiq_q (swi_fiq_q),
   .irq_o     (irq_o),
   .fiq_o     (fiq_o)
);

// File: tb/tb_irq_fiq_ctrl.sv
module tb_irq_fiq_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int AW = 12;

   localparam logic [AW-1:0] A_ISTA = 12'h000, A_ISIG = 12'h004, A_IEN = 12'h008, A_ICLR = 12'h00C;
   localparam logic [AW-1:0] A_FSTA = 12'h100, A_FSIG = 12'h104, A_FEN = 12'h108, A_FCLR = 12'h10C;
   localparam logic [AW-1:0] A_SWI  = 12'h010;

   typedef struct packed {
      logic [31:0] src;
      logic [31:0] sig;
      logic [31:0] ista;
      logic [31:0] fsta;
      logic        irq;
      logic        fiq;
   } vec_t;

   // masks during the walk: normal = 0x0000F000, fast = 0x00000F00
   localparam int NV = 6;
   localparam vec_t VEC [NV] = '{
      '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},
      '{32'h0000_1000, 32'h0000_1000, 32'h0000_1000, 32'h0000_0000, 1'b1, 1'b0},
      '{32'h0000_0100, 32'h0000_0101, 32'h0000_0001, 32'h0000_0101, 1'b0, 1'b1},
      '{32'h0001_0000, 32'h0001_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},
      '{32'hFFFF_FFFF, 32'hFFFF_FFFD, 32'h0000_F001, 32'h0000_0F01, 1'b1, 1'b1},
      '{32'h0000_0003, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic [DW-1:0] src_i = '0;
   logic          irq_o, fiq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_fiq_ctrl #(.DATA_W(DW), .ADDR_W(AW), .OUT_REG(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .src_i(src_i), .irq_o(irq_o), .fiq_o(fiq_o)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      addr = a; wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
      addr = a;
      #1;
      chk(req, rd_data, exp);
   endtask

   // outputs are registered: wait one edge after the state settles
   task automatic out_chk(input string req, input logic ei, input logic ef);
      @(negedge clk);
      chk({req, " irq_o"}, {31'b0, irq_o}, {31'b0, ei});
      chk({req, " fiq_o"}, {31'b0, fiq_o}, {31'b0, ef});
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      #(CLK_PERIOD * 2 + 1);
      rd_chk("R1 normal status", A_ISTA, '0);
      rd_chk("R1 fast status",   A_FSTA, '0);
      rd_chk("R1 normal mask",   A_IEN,  '0);
      rd_chk("R1 fast mask",     A_FEN,  '0);
      chk("R1 outputs", {30'b0, irq_o, fiq_o}, '0);
      @(negedge clk);
      rst_n = 1'b1;

      // R7 cross clear during setup
      wr(A_IEN, 32'h0000_FF00);
      wr(A_FEN, 32'h0000_0F00);
      rd_chk("R7 normal mask after fast set", A_IEN, 32'h0000_F000);
      rd_chk("R5 fast mask",                  A_FEN, 32'h0000_0F00);

      // R2 R3 R4 R10 vector walk
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         src_i = VEC[i].src;
         rd_chk($sformatf("R2 normal sig v%0d", i), A_ISIG, VEC[i].sig);
         rd_chk($sformatf("R2 fast sig v%0d", i),   A_FSIG, VEC[i].sig);
         rd_chk($sformatf("R3 normal sta v%0d", i), A_ISTA, VEC[i].ista);
         rd_chk($sformatf("R3 fast sta v%0d", i),   A_FSTA, VEC[i].fsta);
         out_chk($sformatf("R4 R10 v%0d", i), VEC[i].irq, VEC[i].fiq);
      end

      // R5 writing zero keeps the mask
      src_i = 32'h0000_1000;
      wr(A_IEN, 32'h0);
      rd_chk("R5 zero write keeps mask", A_IEN, 32'h0000_F000);
      out_chk("R5 request held", 1'b1, 1'b0);

      // R6 clear removes only written bits
      wr(A_ICLR, 32'h0000_1000);
      rd_chk("R6 mask after clear", A_IEN, 32'h0000_E000);
      out_chk("R6 request dropped", 1'b0, 1'b0);

      // R9 write-only and unmapped reads, mask bits 1:0
      rd_chk("R9 normal clear reads 0", A_ICLR, '0);
      rd_chk("R9 fast clear reads 0",   A_FCLR, '0);
      rd_chk("R9 swi reads 0",          A_SWI,  '0);
      rd_chk("R9 unmapped reads 0",     12'h020, '0);
      wr(A_FEN, 32'h0000_0003);
      rd_chk("R9 mask bits 1:0", A_FEN, 32'h0000_0F00);

      // R7 moving one line from normal to fast
      src_i = 32'h0001_0000;
      wr(A_IEN, 32'h0001_0000);
      out_chk("R7 routed normal", 1'b1, 1'b0);
      wr(A_FEN, 32'h0001_0000);
      rd_chk("R7 normal bit cleared", A_IEN, 32'h0000_E000);
      out_chk("R7 routed fast", 1'b0, 1'b1);

      // R8 programmed interrupts ignore masks
      wr(A_ICLR, 32'hFFFF_FFFF);
      wr(A_FCLR, 32'hFFFF_FFFF);
      src_i = 32'h0;
      wr(A_SWI, 32'h0000_0004);
      rd_chk("R8 fast sta", A_FSTA, 32'h0000_0003);
      rd_chk("R8 fast sig", A_FSIG, 32'h0000_0003);
      rd_chk("R8 normal sta fiq bit", A_ISTA, 32'h0000_0001);
      out_chk("R8 fast prog", 1'b0, 1'b1);
      wr(A_SWI, 32'h0000_0002);
      rd_chk("R8 normal sta", A_ISTA, 32'h0000_0002);
      rd_chk("R8 fast sta cleared", A_FSTA, 32'h0000_0000);
      out_chk("R8 normal prog", 1'b1, 1'b0);
      wr(A_SWI, 32'h0000_0000);
      rd_chk("R8 all cleared", A_ISTA, 32'h0);
      out_chk("R8 outputs cleared", 1'b0, 1'b0);

      // R1 reset in mid run
      wr(A_IEN, 32'h0000_0F00);
      wr(A_SWI, 32'h0000_0006);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      rd_chk("R1 mask after reset", A_IEN, '0);
      rd_chk("R1 sta after reset", A_FSTA, '0);
      chk("R1 outputs after reset", {30'b0, irq_o, fiq_o}, '0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule